// File: doc/BRIEF.md
# YUV to RGB Pixel Formatter with Error Diffusion

This block sits at the end of a video input path. It takes a stream of scaled YUV 4:2:2 pixels, one pixel per valid beat, and rebuilds full chroma for every pixel by giving both pixels of a pair the same Cb/Cr values. Depending on the selected output format it either keeps the pixels as YUV 4:2:2 or converts them to RGB with fixed-point BT.601 arithmetic. It then packs them into 32-bit words and presents each finished word for one cycle on a valid/data output. There is no backpressure.

Five word layouts are available: YUV 4:2:2, two 16-bit RGB formats (5:6:5 and 5:5:5), and 24-bit RGB either one pixel per word or packed four pixels into three words. When the output is one of the 16-bit RGB formats, an optional error diffusion stage carries the bits lost in truncation to the same channel of the next pixel on the line. This reduces visible banding. Each line begins with a start-of-line flag on its first pixel. The flag restarts chroma pairing, word packing and the carried error.

The format and diffusion controls are expected to stay constant while pixels are in flight.

Top module: `yuv_rgb_packer`

## Requirements
- R1: Pixels alternate between carrying Cb (even position in the line, counted from the pixel flagged as start of line) and Cr (odd position). Both pixels of a pair are processed with that pair's Cb and Cr. Idle cycles between pixels do not change the pairing.
- R2: In RGB formats, with d = Y-16, u = Cb-128 and v = Cr-128: R = clip((298d + 409v + 128) >> 8), G = clip((298d - 208v - 100u + 128) >> 8), B = clip((298d + 516u + 128) >> 8). The shift is arithmetic and clip limits to 0..255, so Cb = Cr = 128 gives R = G = B.
- R3: Format code 0 (YUV 4:2:2) emits one word per pair: bits 7:0 Y of the even pixel, 15:8 Cb, 23:16 Y of the odd pixel, 31:24 Cr.
- R4: Format code 1 (RGB 5:6:5) gives each pixel the 16 bits {R[7:3], G[7:2], B[7:3]}. Two pixels make one word, with the earlier pixel in bits 15:0.
- R5: Format code 2 (RGB 5:5:5) gives each pixel the 16 bits {0, R[7:3], G[7:3], B[7:3]} and packs them two per word as in R4.
- R6: Format code 3 (24-bit unpacked) emits one word per pixel: {8'h00, R, G, B}.
- R7: Format code 4 (24-bit packed) forms a byte stream B, G, R for each pixel in turn. It emits a word for every four bytes, with the earliest byte in bits 7:0, so four pixels fill three words.
- R8: With diffusion enabled in format 1 or 2, each channel adds the error carried from the previous pixel, saturates the sum at 255, keeps its top bits, and carries the dropped low bits (2 for G in 5:6:5, 3 otherwise) to the next pixel. The first pixel of a line uses zero error. In formats 0, 3 and 4 the diffusion control has no effect.
- R9: A start-of-line pixel restarts word packing at the first slot of a word, and any partly filled word from the previous line is discarded.
- R10: No word is valid after reset. With pixels on consecutive cycles, a word is valid three clock edges after the edge that samples the pixel completing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_fmt | input | 3 | Output format code (0..4, see R3 to R7) |
| cfg_diffuse | input | 1 | Enable error diffusion for the 16-bit RGB formats |
| pix_valid | input | 1 | Pixel beat valid |
| pix_sol | input | 1 | Pixel is the first of a line |
| pix_y | input | 8 | Luma of the pixel |
| pix_c | input | 8 | Cb on even pixels, Cr on odd pixels |
| word_valid | output | 1 | Output word valid for this cycle |
| word_data | output | 32 | Output word |

## Verification
A word depends on a pair of pixels. The even pixel waits in the pairing stage for its partner, and from there every pixel passes three registers: pairing, conversion and packing. With contiguous input, a word therefore appears three edges after the pixel that completes it. The bench checks this directly by stamping the sampling edge of the completing pixel and comparing it with the edge at which the word is seen. All other checks avoid depending on that timing. A monitor samples word_valid on the falling edge into a list, each scenario drains at least eight idle cycles before comparing, and word count and content are then checked against a line model built from the requirement formulas.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  // Component width and output word width
  localparam int CW = 8;
  localparam int WW = 32;
  // Width of the carried diffusion error (bits dropped for a 5-bit field)
  localparam int EW = CW - 5;

  typedef enum logic [2:0] {
    FMT_YUV422  = 3'd0,
    FMT_RGB565  = 3'd1,
    FMT_RGB555  = 3'd2,
    FMT_RGB888U = 3'd3,
    FMT_RGB888P = 3'd4
  } ofmt_e;

  // One pixel with full chroma
  typedef struct packed {
    logic [CW-1:0] y;
    logic [CW-1:0] cb;
    logic [CW-1:0] cr;
  } yuv_t;

  // Three channels: [2]=R or Y, [1]=G or Cb, [0]=B or Cr
  typedef logic [2:0][CW-1:0] trip_t;
endpackage

// File: rtl/pxf_pair.sv
module pxf_pair
  import pxf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic [CW-1:0] in_y,
  input  logic [CW-1:0] in_c,
  output logic          px_valid,
  output logic          px_sol,
  output yuv_t          px
);
  // control state
  logic odd_q, odd_d;
  logic pend_q, pend_d;
  logic pv_q, pv_d;
  logic ps_q, ps_d;
  // data state
  logic [CW-1:0] ev_y_q, ev_cb_q;
  logic          ev_sol_q;
  logic [CW-1:0] hy_q, hcb_q, hcr_q;
  yuv_t          px_q, px_d;
  logic          take_odd, take_even, load;

  always_comb begin
    take_odd  = in_valid && !in_sol && odd_q;
    take_even = in_valid && !take_odd;
    odd_d     = odd_q;
    if (in_valid) odd_d = in_sol ? 1'b1 : !odd_q;
    pend_d    = take_odd;
    load      = take_odd || pend_q;
    pv_d      = load;
    ps_d      = take_odd && ev_sol_q;
    if (take_odd) begin
      px_d.y  = ev_y_q;
      px_d.cb = ev_cb_q;
      px_d.cr = in_c;
    end else begin
      px_d.y  = hy_q;
      px_d.cb = hcb_q;
      px_d.cr = hcr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q  <= 1'b0;
      pend_q <= 1'b0;
      pv_q   <= 1'b0;
      ps_q   <= 1'b0;
    end else begin
      odd_q  <= odd_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
      ps_q   <= ps_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_even) begin
      ev_y_q   <= in_y;
      ev_cb_q  <= in_c;
      ev_sol_q <= in_sol;
    end
    if (take_odd) begin
      hy_q  <= in_y;
      hcb_q <= ev_cb_q;
      hcr_q <= in_c;
    end
    if (load) px_q <= px_d;
  end

  assign px_valid = pv_q;
  assign px_sol   = ps_q;
  assign px       = px_q;

  // The odd pixel of a pair must enter conversion on the cycle after its partner
  AST_ODD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (px_valid && !px_sol)); // R1
endmodule

// File: rtl/pxf_csc.sv
module pxf_csc
  import pxf_pkg::*;
#(
  parameter int Y_OFS = 16,
  parameter int C_OFS = 128,
  parameter int K_Y   = 298,
  parameter int K_RV  = 409,
  parameter int K_GV  = 208,
  parameter int K_GU  = 100,
  parameter int K_BU  = 516,
  parameter int FRAC  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] fmt,
  input  logic       px_valid,
  input  logic       px_sol,
  input  yuv_t       px,
  output logic       cv_valid,
  output logic       cv_sol,
  output trip_t      cv
);
  localparam int AW  = 2*CW + 6;
  localparam int RND = 1 << (FRAC - 1);

  logic signed [AW-1:0] yd, ud, vd, ys;
  logic signed [AW-1:0] r_acc, g_acc, b_acc;
  logic                 is_rgb;
  trip_t                cv_d, cv_q;
  logic                 cvv_q, cvs_q;

  function automatic logic [CW-1:0] clip(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] s;
    s = a >>> FRAC;
    if (s[AW-1])            return '0;
    else if (|s[AW-2:CW])   return '1;
    else                    return s[CW-1:0];
  endfunction

  always_comb begin
    is_rgb = (fmt == FMT_RGB565) || (fmt == FMT_RGB555) ||
             (fmt == FMT_RGB888U) || (fmt == FMT_RGB888P);
    yd    = $signed({{(AW-CW){1'b0}}, px.y})  - AW'(Y_OFS);
    ud    = $signed({{(AW-CW){1'b0}}, px.cb}) - AW'(C_OFS);
    vd    = $signed({{(AW-CW){1'b0}}, px.cr}) - AW'(C_OFS);
    ys    = yd * AW'(K_Y) + AW'(RND);
    r_acc = ys + vd * AW'(K_RV);
    g_acc = ys - vd * AW'(K_GV) - ud * AW'(K_GU);
    b_acc = ys + ud * AW'(K_BU);
    if (is_rgb) begin
      cv_d[2] = clip(r_acc);
      cv_d[1] = clip(g_acc);
      cv_d[0] = clip(b_acc);
    end else begin
      cv_d[2] = px.y;
      cv_d[1] = px.cb;
      cv_d[0] = px.cr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cvv_q <= 1'b0;
      cvs_q <= 1'b0;
    end else begin
      cvv_q <= px_valid;
      cvs_q <= px_valid && px_sol;
    end
  end

  always_ff @(posedge clk) begin
    if (px_valid) cv_q <= cv_d;
  end

  assign cv_valid = cvv_q;
  assign cv_sol   = cvs_q;
  assign cv       = cv_q;

  // Neutral chroma must produce a grey pixel
  AST_GREY_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && is_rgb && px.cb == CW'(C_OFS) && px.cr == CW'(C_OFS))
      |=> (cv[2] == cv[1] && cv[1] == cv[0])); // R2
endmodule

// File: rtl/pxf_pack.sv
module pxf_pack
  import pxf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    fmt,
  input  logic          diffuse,
  input  logic          cv_valid,
  input  logic          cv_sol,
  input  trip_t         cv,
  output logic          out_valid,
  output logic [WW-1:0] out_data
);
  localparam int HW = WW / 2;
  localparam int PW = 3 * CW;

  logic          is565, is16, dith_on;
  logic [EW-1:0] err_q [3];
  logic [EW-1:0] err_d [3];
  logic [CW-1:0] qch   [3];
  logic [PW-1:0] q24;
  logic [HW-1:0] half;
  logic [1:0]    ph_q, ph_d, ph_use;
  logic [PW-1:0] hold_q, hold_d;
  logic          ov_q, emit;
  logic [WW-1:0] od_q, word_d;

  assign is565   = (fmt == FMT_RGB565);
  assign is16    = is565 || (fmt == FMT_RGB555);
  assign dith_on = diffuse && is16;

  // Per-channel error diffusion and truncation remainder
  for (genvar i = 0; i < 3; i++) begin : g_ch
    logic [EW-1:0] add, mask;
    logic [CW:0]   sum;
    logic [CW-1:0] sat;
    assign mask     = (is565 && i == 1) ? {1'b0, {(EW-1){1'b1}}} : {EW{1'b1}};
    assign add      = (dith_on && !cv_sol) ? err_q[i] : '0;
    assign sum      = {1'b0, cv[i]} + {{(CW+1-EW){1'b0}}, add};
    assign sat      = sum[CW] ? '1 : sum[CW-1:0];
    assign qch[i]   = sat;
    assign err_d[i] = dith_on ? (sat[EW-1:0] & mask) : '0;
  end

  assign q24    = {qch[2], qch[1], qch[0]};
  assign ph_use = cv_sol ? 2'd0 : ph_q;

  always_comb begin
    case (fmt)
      FMT_RGB565: half = {qch[2][CW-1:3], qch[1][CW-1:2], qch[0][CW-1:3]};
      FMT_RGB555: half = {1'b0, qch[2][CW-1:3], qch[1][CW-1:3], qch[0][CW-1:3]};
      default:    half = ph_use[0] ? {cv[0], cv[2]} : {cv[1], cv[2]};
    endcase
  end

  always_comb begin
    ph_d   = ph_q;
    hold_d = hold_q;
    emit   = 1'b0;
    word_d = '0;
    if (cv_valid) begin
      case (fmt)
        FMT_RGB888U: begin
          emit   = 1'b1;
          word_d = {{(WW-PW){1'b0}}, q24};
          ph_d   = 2'd0;
        end
        FMT_RGB888P: begin
          case (ph_use)
            2'd0: begin
              hold_d = q24;
              ph_d   = 2'd1;
            end
            2'd1: begin
              emit   = 1'b1;
              word_d = {q24[CW-1:0], hold_q};
              hold_d = {{CW{1'b0}}, q24[PW-1:CW]};
              ph_d   = 2'd2;
            end
            2'd2: begin
              emit   = 1'b1;
              word_d = {q24[2*CW-1:0], hold_q[2*CW-1:0]};
              hold_d = {{(2*CW){1'b0}}, q24[PW-1:2*CW]};
              ph_d   = 2'd3;
            end
            default: begin
              emit   = 1'b1;
              word_d = {q24, hold_q[CW-1:0]};
              ph_d   = 2'd0;
            end
          endcase
        end
        default: begin
          if (!ph_use[0]) begin
            hold_d[HW-1:0] = half;
            ph_d           = 2'd1;
          end else begin
            emit   = 1'b1;
            word_d = {half, hold_q[HW-1:0]};
            ph_d   = 2'd0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ph_q <= 2'd0;
      for (int i = 0; i < 3; i++) err_q[i] <= '0;
    end else begin
      ov_q <= emit;
      if (cv_valid) begin
        ph_q <= ph_d;
        for (int i = 0; i < 3; i++) err_q[i] <= err_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cv_valid) hold_q <= hold_d;
    if (emit)     od_q   <= word_d;
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  AST_UNPACKED_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt == FMT_RGB888U) |-> (out_data[WW-1:PW] == '0)); // R6
  AST_SOL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_valid && cv_sol) |=> (ph_q == 2'd1 || fmt == FMT_RGB888U)); // R9
  AST_WORD_FROM_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(cv_valid)); // R10
endmodule

// File: rtl/yuv_rgb_packer.sv
module yuv_rgb_packer
  import pxf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_fmt,
  input  logic          cfg_diffuse,
  input  logic          pix_valid,
  input  logic          pix_sol,
  input  logic [CW-1:0] pix_y,
  input  logic [CW-1:0] pix_c,
  output logic          word_valid,
  output logic [WW-1:0] word_data
);
  logic [1:0] rs_q;
  logic       rst_core_n;
  logic       px_valid, px_sol, cv_valid, cv_sol;
  yuv_t       px;
  trip_t      cv;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  pxf_pair u_pair (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .in_valid (pix_valid),
    .in_sol   (pix_sol),
    .in_y     (pix_y),
    .in_c     (pix_c),
    .px_valid (px_valid),
    .px_sol   (px_sol),
    .px       (px)
  );

  pxf_csc u_csc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .fmt      (cfg_fmt),
    .px_valid (px_valid),
    .px_sol   (px_sol),
    .px       (px),
    .cv_valid (cv_valid),
    .cv_sol   (cv_sol),
    .cv       (cv)
  );

  pxf_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .fmt       (cfg_fmt),
    .diffuse   (cfg_diffuse),
    .cv_valid  (cv_valid),
    .cv_sol    (cv_sol),
    .cv        (cv),
    .out_valid (word_valid),
    .out_data  (word_data)
  );
endmodule

// File: tb/yuv_rgb_packer_tb.sv
`timescale 1ns/1ps
module yuv_rgb_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_fmt;
  logic        cfg_diffuse;
  logic        pix_valid, pix_sol;
  logic [7:0]  pix_y, pix_c;
  logic        word_valid;
  logic [31:0] word_data;

  int nchk = 0, nfail = 0, cyc = 0, last_smp = 0;
  bit done = 0;
  int ly [16];
  int lcb [8];
  int lcr [8];
  logic [31:0] exp_q [$];
  logic [31:0] got_q [$];
  int          got_cyc [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  yuv_rgb_packer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_diffuse(cfg_diffuse),
    .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_y(pix_y), .pix_c(pix_c),
    .word_valid(word_valid), .word_data(word_data)
  );

  always @(negedge clk) begin
    if (word_valid) begin
      got_q.push_back(word_data);
      got_cyc.push_back(cyc);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic int clip(input int a);
    int s;
    s = a >>> 8;
    if (s < 0) return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  function automatic logic [23:0] to_rgb(input int y, input int cb, input int cr);
    int d, u, v;
    d = y - 16; u = cb - 128; v = cr - 128;
    return {8'(clip(298*d + 409*v + 128)),
            8'(clip(298*d - 208*v - 100*u + 128)),
            8'(clip(298*d + 516*u + 128))};
  endfunction

  task automatic set_pair(input int p, input int y0, input int y1, input int cb, input int cr);
    ly[2*p] = y0; ly[2*p+1] = y1; lcb[p] = cb; lcr[p] = cr;
  endtask

  // Line model: appends the words one line of n pixels must produce
  task automatic model_line(input int fmt, input bit dith, input int n);
    int er [3];
    int bytes [$];
    logic [15:0] prev;
    for (int c = 0; c < 3; c++) er[c] = 0;
    prev = '0;
    for (int k = 0; k < n; k++) begin
      logic [23:0] rgb;
      int ch [3];
      int qv [3];
      logic [15:0] h;
      rgb = to_rgb(ly[k], lcb[k/2], lcr[k/2]);
      ch[2] = int'(rgb[23:16]); ch[1] = int'(rgb[15:8]); ch[0] = int'(rgb[7:0]);
      case (fmt)
        0: if (k % 2 == 1)
             exp_q.push_back({8'(lcr[k/2]), 8'(ly[k]), 8'(lcb[k/2]), 8'(ly[k-1])});
        1, 2: begin
          for (int c = 0; c < 3; c++) begin
            int s, dr;
            dr = (fmt == 1 && c == 1) ? 2 : 3;
            s = ch[c] + (dith ? er[c] : 0);
            if (s > 255) s = 255;
            qv[c] = s >> dr;
            if (dith) er[c] = s % (1 << dr);
          end
          if (fmt == 1) h = {5'(qv[2]), 6'(qv[1]), 5'(qv[0])};
          else          h = {1'b0, 5'(qv[2]), 5'(qv[1]), 5'(qv[0])};
          if (k % 2 == 0) prev = h;
          else exp_q.push_back({h, prev});
        end
        3: exp_q.push_back({8'h00, rgb});
        default: begin
          bytes.push_back(ch[0]); bytes.push_back(ch[1]); bytes.push_back(ch[2]);
          while (bytes.size() >= 4) begin
            exp_q.push_back({8'(bytes[3]), 8'(bytes[2]), 8'(bytes[1]), 8'(bytes[0])});
            for (int b = 0; b < 4; b++) void'(bytes.pop_front());
          end
        end
      endcase
    end
  endtask

  task automatic send_line(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_sol   = (k == 0);
      pix_y     = 8'(ly[k]);
      pix_c     = (k % 2 == 0) ? 8'(lcb[k/2]) : 8'(lcr[k/2]);
      last_smp  = cyc + 1;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        pix_valid = 1'b0; pix_sol = 1'b0;
      end
    end
  endtask

  task automatic idle_drain();
    @(negedge clk);
    pix_valid = 1'b0; pix_sol = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(got_q.size() == exp_q.size(), {req, " word count"}, 32'(got_q.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete(); got_cyc.delete(); exp_q.delete();
  endtask

  task automatic fill_ramp(input int seed);
    for (int p = 0; p < 8; p++)
      set_pair(p, (seed + 37*p) % 256, (seed + 37*p + 90) % 256,
               (seed*3 + 61*p) % 256, (seed*7 + 29*p + 40) % 256);
  endtask

  task automatic t_reset();
    check(word_valid == 1'b0, "R10 reset output idle", 32'(word_valid), 32'd0);
  endtask

  task automatic t_yuv();
    cfg_fmt = 3'd0; cfg_diffuse = 1'b0;
    fill_ramp(11);
    model_line(0, 0, 8);
    send_line(8, 0);
    idle_drain();
    compare("R3 yuv contiguous");
    model_line(0, 0, 8);
    send_line(8, 2);
    idle_drain();
    compare("R1 yuv with gaps");
  endtask

  task automatic t_rgb565();
    cfg_fmt = 3'd1; cfg_diffuse = 1'b0;
    set_pair(0, 16, 235, 128, 128);
    set_pair(1, 100, 180, 128, 128);
    set_pair(2, 255, 250, 90, 255);
    set_pair(3, 0, 60, 0, 200);
    set_pair(4, 128, 64, 255, 0);
    set_pair(5, 200, 30, 40, 90);
    model_line(1, 0, 12);
    send_line(12, 0);
    idle_drain();
    compare("R2 R4 rgb565 conversion");
  endtask

  task automatic t_rgb555();
    cfg_fmt = 3'd2; cfg_diffuse = 1'b0;
    fill_ramp(23);
    model_line(2, 0, 10);
    send_line(10, 1);
    idle_drain();
    compare("R5 rgb555");
  endtask

  task automatic t_unpacked();
    cfg_fmt = 3'd3; cfg_diffuse = 1'b1;
    fill_ramp(5);
    model_line(3, 0, 8);
    send_line(8, 0);
    idle_drain();
    compare("R6 R8 unpacked, diffusion ignored");
    cfg_diffuse = 1'b0;
  endtask

  task automatic t_packed();
    cfg_fmt = 3'd4; cfg_diffuse = 1'b1;
    fill_ramp(77);
    model_line(4, 0, 8);
    send_line(8, 0);
    idle_drain();
    compare("R7 packed 24-bit, diffusion ignored");
    cfg_diffuse = 1'b0;
  endtask

  task automatic t_dither(input int fmt, input string req);
    cfg_fmt = 3'(fmt); cfg_diffuse = 1'b1;
    for (int p = 0; p < 8; p++)
      set_pair(p, 21 + 13*p, 27 + 13*p, 101 + 9*p, 150 - 7*p);
    set_pair(7, 250, 254, 60, 250);
    model_line(fmt, 1, 16);
    model_line(fmt, 1, 16);
    send_line(16, 0);
    send_line(16, 0);
    idle_drain();
    compare(req);
    cfg_diffuse = 1'b0;
  endtask

  task automatic t_sol_phase();
    cfg_fmt = 3'd4; cfg_diffuse = 1'b0;
    fill_ramp(140);
    model_line(4, 0, 6);
    model_line(4, 0, 8);
    send_line(6, 0);
    send_line(8, 0);
    idle_drain();
    compare("R9 packed restart at line start");
    cfg_fmt = 3'd1;
    fill_ramp(9);
    model_line(1, 0, 2);
    model_line(1, 0, 4);
    send_line(2, 0);
    send_line(4, 0);
    idle_drain();
    compare("R9 16-bit restart at line start");
  endtask

  task automatic t_latency();
    int smp;
    cfg_fmt = 3'd0; cfg_diffuse = 1'b0;
    fill_ramp(50);
    model_line(0, 0, 2);
    send_line(2, 0);
    smp = last_smp;
    idle_drain();
    if (got_cyc.size() > 0)
      check(got_cyc[0] == smp + 3, "R10 latency", 32'(got_cyc[0]), 32'(smp + 3));
    else
      check(1'b0, "R10 latency no word", 32'd0, 32'(smp + 3));
    compare("R10 latency word");
  endtask

  initial begin
    rst_n = 1'b0; cfg_fmt = 3'd0; cfg_diffuse = 1'b0;
    pix_valid = 1'b0; pix_sol = 1'b0; pix_y = '0; pix_c = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latency();
    t_yuv();
    t_rgb565();
    t_rgb555();
    t_unpacked();
    t_packed();
    t_dither(1, "R8 diffusion rgb565 two lines");
    t_dither(2, "R8 diffusion rgb555 two lines");
    t_sol_phase();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule